// File: doc/BRIEF.md
# Truth-Table Mask Logic Unit

This unit combines two predicate mask words lane by lane. Each lane holds one bit. A 4-bit code selects one of the sixteen two-input Boolean functions, and that function is applied to every lane on its own. No carry or other signal passes between lanes.

A second, named encoding covers the common fixed opcodes: AND, OR, XOR, ANDN, ORN and XORN. A decoder translates each named opcode into the matching table code. A named opcode that is not recognised gives a zero word and raises an error flag for that single result. Clear, set, copy and invert are reached as ordinary table codes.

With `REGISTERED=1`, which is the default, the result is registered. It appears one cycle after the input strobe and carries its own valid flag. With `REGISTERED=0` the output is a pure combinational path.

Top module: `mask_logic_unit`

## Requirements
- R1: With `named_op`=0, each result bit `i` equals bit `{src1[i],src2[i]}` of `func`. The index is src1 times 2 plus src2, so `func[0]` is used when both bits are 0, `func[1]` when only src2 is 1, `func[2]` when only src1 is 1, and `func[3]` when both are 1.
- R2: Table code 4'h0 yields an all-zero word and 4'hF yields an all-ones word, whatever the sources hold.
- R3: Table codes 4'h8, 4'hE, 4'h6, 4'h1, 4'h7 and 4'h9 yield AND, OR, XOR, NOR, NAND and XNOR of the sources, in that order.
- R4: Table code 4'hC copies src1, 4'hA copies src2, 4'h3 gives ~src1 and 4'h5 gives ~src2.
- R5: Table code 4'h4 gives src1&~src2, 4'h2 gives src2&~src1, 4'hD gives src1|~src2 and 4'hB gives src2|~src1.
- R6: With `named_op`=1, `func` values 0 to 5 select AND, OR, XOR, ANDN (src1&~src2), ORN (src1|~src2) and XORN (src1^~src2), in that order.
- R7: With `named_op`=1, `func` values 6 to 15 yield a zero result. `illegal_op` is raised together with `out_valid` for exactly that one result.
- R8: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. `result` shows the value for that input.
- R9: During synchronous reset (`rst_n` low at a clock edge), `out_valid`, `illegal_op` and `result` are cleared to zero.
- R10: When `in_valid` is low, `result` keeps its previous value and `illegal_op` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| named_op | input | 1 | 0: `func` is a truth table; 1: `func` is a named opcode |
| func | input | 4 | Truth-table code or named opcode number |
| src1 | input | XLEN | First mask word |
| src2 | input | XLEN | Second mask word |
| out_valid | output | 1 | Result strobe |
| result | output | XLEN | Combined mask word |
| illegal_op | output | 1 | Unrecognised named opcode, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a single word that drives all four truth-table entries. The bench uses source words whose lanes cycle through all four bit pairs, so one result exposes every bit of `func` in a single cycle.

The bench also interleaves illegal named opcodes with legal ones, idle gaps and a reset in the middle of a stream. This shows that the error pulse lasts one result only and that the held result survives idle cycles.

// File: rtl/mlu_pkg.sv
// Package: shared encodings for the mask logic unit.
// Assumes: truth-table index is {src1_bit, src2_bit}.
package mlu_pkg;
    typedef logic [3:0] tt_code_t;

    // Truth-table codes for the named operations.
    localparam tt_code_t TT_AND  = 4'h8;
    localparam tt_code_t TT_OR   = 4'hE;
    localparam tt_code_t TT_XOR  = 4'h6;
    localparam tt_code_t TT_ANDN = 4'h4;
    localparam tt_code_t TT_ORN  = 4'hD;
    localparam tt_code_t TT_XORN = 4'h9;
    localparam tt_code_t TT_ZERO = 4'h0;

    // Named opcode numbers carried on func when named_op is set.
    typedef enum logic [3:0] {
        NOP_AND  = 4'd0,
        NOP_OR   = 4'd1,
        NOP_XOR  = 4'd2,
        NOP_ANDN = 4'd3,
        NOP_ORN  = 4'd4,
        NOP_XORN = 4'd5
    } named_op_e;
endpackage

// File: rtl/mlu_decode.sv
// Module: mlu_decode
// Turns the func/named_op pair into a truth-table code and an illegal flag.
// Assumes: a raw table code is always legal; only named opcodes can be illegal.
module mlu_decode
    import mlu_pkg::*;
(
    input  logic     named_op,
    input  logic [3:0] func,
    output tt_code_t code,
    output logic     illegal
);
    // Purpose: map named opcodes onto table codes, pass raw codes through.
    always_comb begin
        code    = func;
        illegal = 1'b0;
        if (named_op) begin
            case (func)
                NOP_AND:  code = TT_AND;
                NOP_OR:   code = TT_OR;
                NOP_XOR:  code = TT_XOR;
                NOP_ANDN: code = TT_ANDN;
                NOP_ORN:  code = TT_ORN;
                NOP_XORN: code = TT_XORN;
                default: begin
                    code    = TT_ZERO;
                    illegal = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/mlu_lane_array.sv
// Module: mlu_lane_array
// One 4:1 selector per lane picks the code bit addressed by the lane's two source bits.
// Assumes: lanes are fully independent; no carry between lanes.
module mlu_lane_array
    import mlu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  tt_code_t          code,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic [XLEN-1:0]   y
);
    // Purpose: replicate the lane selector across the word.
    for (genvar g = 0; g < XLEN; g++) begin : g_lane
        logic [1:0] sel;
        assign sel  = {a[g], b[g]};
        assign y[g] = code[sel];
    end
endmodule

// File: rtl/mlu_out_stage.sv
// Module: mlu_out_stage
// Optional output register for the result word, its valid and the illegal flag.
// Assumes: synchronous active-low reset; the result holds while no input is valid.
module mlu_out_stage #(
    parameter int XLEN       = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] d,
    input  logic            ill_in,
    output logic [XLEN-1:0] q,
    output logic            q_valid,
    output logic            q_ill
);
    if (REGISTERED) begin : g_reg
        // Purpose: capture the result on a valid input, clear everything on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q       <= '0;
                q_valid <= 1'b0;
                q_ill   <= 1'b0;
            end else begin
                q_valid <= in_valid;
                q_ill   <= in_valid & ill_in;
                if (in_valid) q <= d;
            end
        end

        AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (q_valid == $past(in_valid))); // R8
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(in_valid)) |-> ($stable(q) && !q_ill)); // R10
        AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            q_ill |-> (q_valid && q == '0)); // R7
        AST_RESET_CLEARS: assert property (@(posedge clk)
            !rst_n |=> (!q_valid && !q_ill && q == '0)); // R9
    end else begin : g_comb
        // Purpose: pass the result straight through.
        assign q       = d;
        assign q_valid = in_valid;
        assign q_ill   = in_valid & ill_in;
    end
endmodule

// File: rtl/mask_logic_unit.sv
// Module: mask_logic_unit (top)
// Applies one of 16 two-input Boolean functions to every lane of two mask words.
// Assumes: func is a truth table when named_op=0, a named opcode number when named_op=1.
module mask_logic_unit
    import mlu_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter bit REGISTERED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            named_op,
    input  logic [3:0]      func,
    input  logic [XLEN-1:0] src1,
    input  logic [XLEN-1:0] src2,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            illegal_op
);
    localparam logic [XLEN-1:0] ALL_ONES = {XLEN{1'b1}};

    tt_code_t        code;
    logic            illegal;
    logic [XLEN-1:0] lanes;
    logic [XLEN-1:0] word;

    mlu_decode u_decode (
        .named_op (named_op),
        .func     (func),
        .code     (code),
        .illegal  (illegal)
    );

    mlu_lane_array #(.XLEN(XLEN)) u_lanes (
        .code (code),
        .a    (src1),
        .b    (src2),
        .y    (lanes)
    );

    // Purpose: force a zero word for an illegal named opcode.
    always_comb word = illegal ? '0 : lanes;

    mlu_out_stage #(.XLEN(XLEN), .REGISTERED(REGISTERED)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        (word),
        .ill_in   (illegal),
        .q        (result),
        .q_valid  (out_valid),
        .q_ill    (illegal_op)
    );

    if (REGISTERED) begin : g_chk
        AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid && !named_op && func == 4'hF))
            |-> (result == ALL_ONES)); // R2
        AST_NAMED_AND: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid && named_op && func == 4'd0))
            |-> (result == $past(src1 & src2))); // R6
    end
endmodule

// File: tb/tb_mask_logic_unit.sv
module tb_mask_logic_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            named_op = 1'b0;
    logic [3:0]      func = '0;
    logic [XLEN-1:0] src1 = '0;
    logic [XLEN-1:0] src2 = '0;
    logic            out_valid;
    logic [XLEN-1:0] result;
    logic            illegal_op;

    int checks = 0;
    int fails  = 0;

    logic [XLEN-1:0] exp_res = '0;
    logic            exp_val = 1'b0;
    logic            exp_ill = 1'b0;
    string           exp_tag = "R9";

    always #5 clk = ~clk;

    mask_logic_unit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .named_op(named_op),
        .func(func), .src1(src1), .src2(src2),
        .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
    );

    task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference: table lookup per lane from the requirement wording.
    function automatic logic [XLEN-1:0] ref_table(logic [3:0] c, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            int idx;
            idx = (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
            r[i] = c[idx];
        end
        return r;
    endfunction

    function automatic string tag_of_code(logic [3:0] c);
        case (c)
            4'h0, 4'hF: return "R2";
            4'h8, 4'hE, 4'h6, 4'h1, 4'h7, 4'h9: return "R3";
            4'hC, 4'hA, 4'h3, 4'h5: return "R4";
            default: return "R5";
        endcase
    endfunction

    // One cycle: check what the previous drive should have produced, then drive anew.
    task automatic cycle(logic v, logic nm, logic [3:0] f, logic [XLEN-1:0] a, logic [XLEN-1:0] b, string tag);
        @(negedge clk);
        check(exp_tag, result, exp_res, "result");
        check(exp_val ? "R8" : "R10", {{(XLEN-1){1'b0}}, out_valid}, {{(XLEN-1){1'b0}}, exp_val}, "out_valid");
        check(exp_ill ? "R7" : "R10", {{(XLEN-1){1'b0}}, illegal_op}, {{(XLEN-1){1'b0}}, exp_ill}, "illegal_op");
        in_valid = v; named_op = nm; func = f; src1 = a; src2 = b;
        exp_val = v;
        exp_ill = 1'b0;
        if (v) begin
            exp_tag = tag;
            if (!nm) exp_res = ref_table(f, a, b);
            else begin
                case (f)
                    4'd0: exp_res = a & b;
                    4'd1: exp_res = a | b;
                    4'd2: exp_res = a ^ b;
                    4'd3: exp_res = a & ~b;
                    4'd4: exp_res = a | ~b;
                    4'd5: exp_res = a ^ ~b;
                    default: begin exp_res = '0; exp_ill = 1'b1; exp_tag = "R7"; end
                endcase
            end
        end else begin
            exp_tag = "R10";
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_res = '0; exp_val = 1'b0; exp_ill = 1'b0; exp_tag = "R9";
    endtask

    initial begin
        logic [XLEN-1:0] pa, pb;
        pa = {(XLEN/16){16'hFF00}};
        pb = {(XLEN/8){8'hF0}};
        apply_reset();
        // R9: reset state is checked by the first cycle.
        cycle(1'b0, 1'b0, 4'h0, '0, '0, "R10");
        // R1-style sweep of all table codes with every lane pair present.
        for (int c = 0; c < 16; c++)
            cycle(1'b1, 1'b0, 4'(c), pa, pb, tag_of_code(4'(c)));
        // R2: clear and set with arbitrary sources.
        cycle(1'b1, 1'b0, 4'h0, '1, '1, "R2");
        cycle(1'b1, 1'b0, 4'hF, '0, '0, "R2");
        // R6 and R7: every named opcode number, legal and illegal.
        for (int n = 0; n < 16; n++)
            cycle(1'b1, 1'b1, 4'(n), pa, pb, n < 6 ? "R6" : "R7");
        // R7 illegal then idle: pulse must drop; R10 hold.
        cycle(1'b1, 1'b1, 4'd9, pa, pb, "R7");
        cycle(1'b0, 1'b1, 4'd9, '1, '1, "R10");
        cycle(1'b1, 1'b0, 4'h6, pa, pb, "R3");
        cycle(1'b0, 1'b0, 4'hF, '1, '0, "R10");
        cycle(1'b0, 1'b0, 4'h0, '0, '1, "R10");
        // R9: reset in the middle of a stream.
        cycle(1'b1, 1'b0, 4'hF, pa, pb, "R2");
        apply_reset();
        cycle(1'b1, 1'b0, 4'hC, pa, pb, "R4");
        // R1: random vectors with random gaps.
        for (int k = 0; k < 400; k++) begin
            logic v, nm;
            v  = ($urandom % 4) != 0;
            nm = ($urandom % 3) == 0;
            cycle(v, nm, 4'($urandom), $urandom, $urandom, nm ? "R6" : "R1");
        end
        cycle(1'b0, 1'b0, 4'h0, '0, '0, "R10");
        cycle(1'b0, 1'b0, 4'h0, '0, '0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule